// File: doc/BRIEF.md
# Test Pattern Receive Monitor

This block is the checking half of a bit error rate tester. It receives one serial bit per strobe and compares the stream with a locally built copy of the expected pattern. The expected pattern is either a pseudo-random sequence from the recurrence x^n + x^y + 1 or a fixed word of up to 32 bits that repeats. The monitor finds the pattern in the incoming data without outside help and reports when it is locked. While locked, it counts every received bit and every bit that differs from the expected pattern.

Lock is kept through sparse random errors. When errors become dense, the monitor drops lock and searches again. The host reads the counters through a snapshot strobe. The strobe moves both live counts into holding registers and starts the live counts again from zero. A bit that arrives in the same cycle as the strobe is not lost.

Top module: `patmon_rx`

## Requirements
- R1: After reset, `in_sync` is 0 and both `err_snap` and `bit_snap` are 0.
- R2: In PRBS mode (`pat_sel`=0), stream bit k equals bit k-`prbs_len` XOR bit k-`prbs_tap`. After enable, the monitor loads its pattern state from the first `prbs_len` accepted bits. It then needs 32 accepted bits that match. `in_sync` is 1 after the clock edge that takes the (`prbs_len`+32)-th clean bit, and is 0 after the edge before it.
- R3: In PRBS mode, a mismatch during the 32-bit check throws away the loaded state. The monitor loads again from the next `prbs_len` bits and checks another 32.
- R4: In word mode (`pat_sel`=1), the expected bit is `word_pat[p]`, with p counting 0 to `word_len`-1, least significant bit first. On a matching bit, p advances. On a mismatch during search, p holds, which slips the expected phase by one bit. Lock comes after 32 consecutive matches. An aligned stream locks on its 32nd bit, and a stream that starts at any phase also locks.
- R5: While `in_sync` is 1, each accepted bit adds one to the 32-bit bit count, and each mismatching bit adds one to the 24-bit error count. Nothing is counted while out of sync or while `rx_valid` is 0.
- R6: While locked, bits are grouped into windows of 64 accepted bits, starting at the first bit after lock. The 6th error in one window drops `in_sync` after that bit's clock edge, and search starts again. A window with 5 errors keeps lock.
- R7: Isolated errors at a rate near 1e-3 do not drop lock, and each one is counted.
- R8: `snap`=1 copies the counts into `err_snap`/`bit_snap`, including any bit accepted in the same cycle, and clears the live counts. The next snapshot therefore holds only bits that came after that cycle.
- R9: Both counts stop at all ones instead of wrapping.
- R10: With `enable`=0, `in_sync` is 0 after the next edge and no bits are counted. Raising `enable` again starts a fresh search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| enable | input | 1 | Tester enable; when low, the monitor is held in search |
| pat_sel | input | 1 | 0 = PRBS, 1 = repeating word |
| prbs_len | input | 6 | PRBS length n (2..32) |
| prbs_tap | input | 6 | PRBS tap y (1..n-1) |
| word_pat | input | 32 | Repeating word, bit 0 first |
| word_len | input | 6 | Word length (1..32) |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | Strobe that accepts `rx_bit` |
| snap | input | 1 | Snapshot-and-clear strobe for the counters |
| in_sync | output | 1 | Pattern lock status |
| err_snap | output | ERR_W (24) | Error count from the last snapshot |
| bit_snap | output | BIT_W (32) | Bit count from the last snapshot |

## Verification
The hardest state to reach is the edge of the loss rule: lock that survives exactly five errors in one window and then fails on the sixth error of the next window. This only works if the bench knows where each window starts. Each scenario therefore enables the monitor again, feeds a clean pattern for an exact number of bits to reach lock, and counts bits from that point. This places every error at a known offset within its window. Counter saturation cannot be reached with the real 24- and 32-bit widths in a short run, so a second copy with 4- and 6-bit counters receives the same stream.

// File: rtl/patmon_pkg.sv
package patmon_pkg;

  typedef enum logic [1:0] {ST_LOAD, ST_VERIFY, ST_SYNC} sync_st_t;

  // Feedback bit of x^len + x^tap + 1; hist[0] is the newest bit.
  function automatic logic prbs_fb(input logic [31:0] hist,
                                   input logic [5:0]  len,
                                   input logic [5:0]  tap);
    logic [4:0] ia;
    logic [4:0] ib;
    ia = 5'(len - 6'd1);
    ib = 5'(tap - 6'd1);
    return hist[ia] ^ hist[ib];
  endfunction

  // Next phase in a word of length len.
  function automatic logic [5:0] phase_next(input logic [5:0] ph,
                                            input logic [5:0] len);
    return ((ph + 6'd1) >= len) ? 6'd0 : ph + 6'd1;
  endfunction

endpackage

// File: rtl/patmon_expect.sv
module patmon_expect
  import patmon_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        step,
  input  logic        ld_rx,
  input  logic        slip,
  input  logic        din,
  input  logic        mode_word,
  input  logic [5:0]  prbs_len,
  input  logic [5:0]  prbs_tap,
  input  logic [31:0] word_pat,
  input  logic [5:0]  word_len,
  output logic        exp_bit
);

  logic [31:0] hist_q;
  logic [5:0]  ph_q;

  assign exp_bit = mode_word ? word_pat[ph_q[4:0]]
                             : prbs_fb(hist_q, prbs_len, prbs_tap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ph_q   <= '0;
    end else if (restart) begin
      hist_q <= '0;
      ph_q   <= '0;
    end else if (step) begin
      if (!mode_word)
        hist_q <= {hist_q[30:0], ld_rx ? din : exp_bit};
      else if (!slip)
        ph_q <= phase_next(ph_q, word_len);
    end
  end

endmodule

// File: rtl/patmon_sync.sv
module patmon_sync
  import patmon_pkg::*;
#(
  parameter int MATCH_RUN = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       valid,
  input  logic       mismatch,
  input  logic       mode_word,
  input  logic [5:0] prbs_len,
  output logic       in_sync,
  output logic       restart,
  output logic       ld_rx,
  output logic       slip,
  output logic       bit_evt,
  output logic       err_evt
);

  localparam int RUN_W = $clog2(MATCH_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int EC_W  = $clog2(LOSS_ERRS + 1);

  sync_st_t         st_q, st_d, cur, init_st;
  logic [5:0]       ld_q, ld_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [EC_W-1:0]  ec_q, ec_d;
  logic             loss;

  assign init_st = mode_word ? ST_VERIFY : ST_LOAD;
  assign cur     = (mode_word && st_q == ST_LOAD) ? ST_VERIFY : st_q;

  assign restart = !enable;
  assign in_sync = (st_q == ST_SYNC);
  assign ld_rx   = (cur == ST_LOAD) && valid;
  assign slip    = (cur == ST_VERIFY) && mismatch;
  assign bit_evt = enable && valid && (cur == ST_SYNC);
  assign err_evt = bit_evt && mismatch;
  assign loss    = err_evt && (ec_q == EC_W'(LOSS_ERRS - 1));

  always_comb begin
    st_d  = cur;
    ld_d  = ld_q;
    run_d = run_q;
    win_d = win_q;
    ec_d  = ec_q;
    if (!enable) begin
      st_d  = init_st;
      ld_d  = '0;
      run_d = '0;
      win_d = '0;
      ec_d  = '0;
    end else if (valid) begin
      case (cur)
        ST_LOAD: begin
          if (ld_q == prbs_len - 6'd1) begin
            st_d  = ST_VERIFY;
            ld_d  = '0;
            run_d = '0;
          end else begin
            ld_d = ld_q + 6'd1;
          end
        end
        ST_VERIFY: begin
          if (mismatch) begin
            run_d = '0;
            if (!mode_word) st_d = ST_LOAD;
          end else if (run_q == RUN_W'(MATCH_RUN - 1)) begin
            st_d  = ST_SYNC;
            run_d = '0;
            win_d = '0;
            ec_d  = '0;
          end else begin
            run_d = run_q + RUN_W'(1);
          end
        end
        default: begin
          if (loss) begin
            st_d  = init_st;
            ld_d  = '0;
            run_d = '0;
          end else if (win_q == WIN_W'(WIN_LEN - 1)) begin
            win_d = '0;
            ec_d  = '0;
          end else begin
            win_d = win_q + WIN_W'(1);
            ec_d  = ec_q + EC_W'(mismatch);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_LOAD;
      ld_q  <= '0;
      run_q <= '0;
      win_q <= '0;
      ec_q  <= '0;
    end else begin
      st_q  <= st_d;
      ld_q  <= ld_d;
      run_q <= run_d;
      win_q <= win_d;
      ec_q  <= ec_d;
    end
  end

endmodule

// File: rtl/patmon_cnt.sv
module patmon_cnt #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         latch,
  output logic [W-1:0] live,
  output logic [W-1:0] held
);

  logic [W-1:0] nxt;

  assign nxt = (inc && live != {W{1'b1}}) ? live + W'(1) : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      held <= '0;
    end else if (latch) begin
      held <= nxt;
      live <= '0;
    end else begin
      live <= nxt;
    end
  end

endmodule

// File: rtl/patmon_rx.sv
module patmon_rx
  import patmon_pkg::*;
#(
  parameter int ERR_W     = 24,
  parameter int BIT_W     = 32,
  parameter int MATCH_RUN = 32,
  parameter int WIN_LEN   = 64,
  parameter int LOSS_ERRS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             pat_sel,
  input  logic [5:0]       prbs_len,
  input  logic [5:0]       prbs_tap,
  input  logic [31:0]      word_pat,
  input  logic [5:0]       word_len,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             snap,
  output logic             in_sync,
  output logic [ERR_W-1:0] err_snap,
  output logic [BIT_W-1:0] bit_snap
);

  logic             exp_bit;
  logic             mismatch;
  logic             restart;
  logic             step;
  logic             ld_rx;
  logic             slip;
  logic             bit_evt;
  logic             err_evt;
  logic [ERR_W-1:0] err_live;
  logic [BIT_W-1:0] bit_live;

  assign mismatch = rx_bit ^ exp_bit;
  assign step     = enable && rx_valid;

  patmon_expect u_expect (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .step      (step),
    .ld_rx     (ld_rx),
    .slip      (slip),
    .din       (rx_bit),
    .mode_word (pat_sel),
    .prbs_len  (prbs_len),
    .prbs_tap  (prbs_tap),
    .word_pat  (word_pat),
    .word_len  (word_len),
    .exp_bit   (exp_bit)
  );

  patmon_sync #(
    .MATCH_RUN (MATCH_RUN),
    .WIN_LEN   (WIN_LEN),
    .LOSS_ERRS (LOSS_ERRS)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .valid     (rx_valid),
    .mismatch  (mismatch),
    .mode_word (pat_sel),
    .prbs_len  (prbs_len),
    .in_sync   (in_sync),
    .restart   (restart),
    .ld_rx     (ld_rx),
    .slip      (slip),
    .bit_evt   (bit_evt),
    .err_evt   (err_evt)
  );

  patmon_cnt #(.W(ERR_W)) u_err_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (err_evt),
    .latch (snap),
    .live  (err_live),
    .held  (err_snap)
  );

  patmon_cnt #(.W(BIT_W)) u_bit_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (bit_evt),
    .latch (snap),
    .live  (bit_live),
    .held  (bit_snap)
  );

endmodule

// File: rtl/patmon_rx_chk.sv
module patmon_rx_chk #(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             rx_valid,
  input logic             snap,
  input logic             in_sync,
  input logic             mismatch,
  input logic             bit_evt,
  input logic             err_evt,
  input logic [ERR_W-1:0] err_live,
  input logic [BIT_W-1:0] bit_live
);

  AST_OFF_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n) !enable |=> !in_sync); // R10
  AST_COUNT_ONLY_SYNCED: assert property (@(posedge clk) disable iff (!rst_n) bit_evt |-> in_sync); // R5
  AST_ERR_WITH_BIT: assert property (@(posedge clk) disable iff (!rst_n) err_evt |-> bit_evt); // R5
  AST_CLEAN_KEEPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n) in_sync && enable && !err_evt |=> in_sync); // R6
  AST_SNAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) snap |=> (bit_live == '0) && (err_live == '0)); // R8
  AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !snap |=> err_live >= $past(err_live)); // R9
  AST_BIT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) !snap |=> bit_live >= $past(bit_live)); // R9
  AST_LOCK_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(in_sync) |-> $past(enable && rx_valid && !mismatch)); // R2

endmodule

bind patmon_rx patmon_rx_chk #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .enable   (enable),
  .rx_valid (rx_valid),
  .snap     (snap),
  .in_sync  (in_sync),
  .mismatch (mismatch),
  .bit_evt  (bit_evt),
  .err_evt  (err_evt),
  .err_live (err_live),
  .bit_live (bit_live)
);

// File: tb/patmon_rx_tb_top.sv
module patmon_rx_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        pat_sel = 1'b0;
  logic [5:0]  prbs_len = 6'd7;
  logic [5:0]  prbs_tap = 6'd6;
  logic [31:0] word_pat = '0;
  logic [5:0]  word_len = 6'd5;
  logic        rx_bit = 1'b0;
  logic        rx_valid = 1'b0;
  logic        snap = 1'b0;

  logic        in_sync, sat_sync;
  logic [23:0] err_snap;
  logic [31:0] bit_snap;
  logic [3:0]  sat_err;
  logic [5:0]  sat_bit;

  int n_chk = 0;
  int n_fail = 0;

  // Bench pattern sources
  int g_k;
  bit g_hist[64];
  bit [31:0] g_seed;
  int w_ph;

  always #(CLK_PERIOD/2) clk = ~clk;

  patmon_rx dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_sel(pat_sel),
    .prbs_len(prbs_len), .prbs_tap(prbs_tap), .word_pat(word_pat), .word_len(word_len),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .snap(snap),
    .in_sync(in_sync), .err_snap(err_snap), .bit_snap(bit_snap)
  );

  patmon_rx #(.ERR_W(4), .BIT_W(6)) sat_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pat_sel(pat_sel),
    .prbs_len(prbs_len), .prbs_tap(prbs_tap), .word_pat(word_pat), .word_len(word_len),
    .rx_bit(rx_bit), .rx_valid(rx_valid), .snap(snap),
    .in_sync(sat_sync), .err_snap(sat_err), .bit_snap(sat_bit)
  );

  task automatic chk(input string req, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Called at a negedge; returns at the next negedge with outputs settled.
  task automatic drive(input bit b, input bit v, input bit lt);
    rx_bit = b; rx_valid = v; snap = lt;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; snap = 1'b0;
  endtask

  task automatic next_pat(output bit b);
    if (pat_sel) begin
      b = word_pat[w_ph];
      w_ph = (w_ph + 1) % int'(word_len);
    end else begin
      if (g_k < int'(prbs_len)) b = g_seed[g_k];
      else b = g_hist[(g_k - int'(prbs_len)) % 64] ^ g_hist[(g_k - int'(prbs_tap)) % 64];
      g_hist[g_k % 64] = b;
      g_k++;
    end
  endtask

  task automatic send_pat(input int cnt, input bit flip);
    for (int i = 0; i < cnt; i++) begin
      bit b;
      next_pat(b);
      drive(b ^ flip, 1'b1, 1'b0);
    end
  endtask

  task automatic restart_mon();
    enable = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    enable = 1'b1;
  endtask

  task automatic acquire_prbs(input string req);
    restart_mon();
    send_pat(int'(prbs_len) + 32, 1'b0);
    chk({req, " lock"}, in_sync, 1);
    drive(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 in_sync", in_sync, 0);
    chk("R1 err_snap", err_snap, 0);
    chk("R1 bit_snap", bit_snap, 0);
  endtask

  task automatic t_prbs_acquire();
    pat_sel = 0; prbs_len = 6'd7; prbs_tap = 6'd6; g_seed = 32'h5B; g_k = 0;
    restart_mon();
    send_pat(7 + 31, 1'b0);
    chk("R2 not yet locked", in_sync, 0);
    send_pat(1, 1'b0);
    chk("R2 locked at n+32", in_sync, 1);
    drive(1'b0, 1'b0, 1'b1);
    send_pat(100, 1'b0);
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 1'b0);  // R5 idle strobe
    send_pat(100, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R5 bit count", bit_snap, 200);
    chk("R5 err count", err_snap, 0);
  endtask

  task automatic t_prbs_restart();
    pat_sel = 0; prbs_len = 6'd15; prbs_tap = 6'd14; g_seed = 32'h3A7C; g_k = 0;
    restart_mon();
    send_pat(15 + 10, 1'b0);
    send_pat(1, 1'b1);
    send_pat(15 + 31, 1'b0);
    chk("R3 reload after verify mismatch", in_sync, 0);
    send_pat(1, 1'b0);
    chk("R3 lock after reload", in_sync, 1);
  endtask

  task automatic t_word();
    pat_sel = 1; word_pat = 32'b10110; word_len = 6'd5;
    w_ph = 0;
    restart_mon();
    send_pat(31, 1'b0);
    chk("R4 aligned not yet", in_sync, 0);
    send_pat(1, 1'b0);
    chk("R4 aligned lock at 32", in_sync, 1);
    drive(1'b0, 1'b0, 1'b1);
    send_pat(64, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R4 word bit count", bit_snap, 64);
    chk("R4 word err count", err_snap, 0);
    restart_mon();
    w_ph = 2;
    for (int i = 0; i < 400 && !in_sync; i++) send_pat(1, 1'b0);
    chk("R4 offset phase lock", in_sync, 1);
    drive(1'b0, 1'b0, 1'b1);
    send_pat(50, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R4 offset bit count", bit_snap, 50);
    chk("R4 offset err count", err_snap, 0);
  endtask

  task automatic t_loss();
    pat_sel = 0; prbs_len = 6'd7; prbs_tap = 6'd6; g_seed = 32'h11; g_k = 0;
    acquire_prbs("R6");
    for (int i = 0; i < 64; i++)
      send_pat(1, (i == 2 || i == 9 || i == 17 || i == 30 || i == 50));
    chk("R6 five errors keep lock", in_sync, 1);
    for (int i = 0; i < 10; i++) send_pat(1, (i >= 5));
    chk("R6 five in window still locked", in_sync, 1);
    send_pat(1, 1'b1);
    chk("R6 sixth error drops lock", in_sync, 0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R5 bits before loss", bit_snap, 75);
    chk("R5 errors before loss", err_snap, 11);
  endtask

  task automatic t_sparse();
    pat_sel = 0; prbs_len = 6'd7; prbs_tap = 6'd6; g_seed = 32'h2D; g_k = 0;
    acquire_prbs("R7");
    for (int i = 0; i < 3000; i++) send_pat(1, (i % 1000 == 500));
    chk("R7 lock held at 1e-3", in_sync, 1);
    drive(1'b0, 1'b0, 1'b1);
    chk("R7 bit count", bit_snap, 3000);
    chk("R7 error count", err_snap, 3);
  endtask

  task automatic t_snap();
    bit b;
    pat_sel = 0; prbs_len = 6'd7; prbs_tap = 6'd6; g_seed = 32'h4E; g_k = 0;
    acquire_prbs("R8");
    send_pat(10, 1'b0);
    next_pat(b);
    drive(~b, 1'b1, 1'b1);
    chk("R8 coincident bit in snapshot", bit_snap, 11);
    chk("R8 coincident error in snapshot", err_snap, 1);
    send_pat(4, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R8 live cleared bits", bit_snap, 4);
    chk("R8 live cleared errors", err_snap, 0);
  endtask

  task automatic t_saturate();
    pat_sel = 0; prbs_len = 6'd7; prbs_tap = 6'd6; g_seed = 32'h6B; g_k = 0;
    acquire_prbs("R9");
    for (int i = 0; i < 256; i++) begin
      int m;
      m = i % 64;
      send_pat(1, (m == 3 || m == 13 || m == 23 || m == 33 || m == 43));
    end
    drive(1'b0, 1'b0, 1'b1);
    chk("R9 wide bit count", bit_snap, 256);
    chk("R9 wide err count", err_snap, 20);
    chk("R9 narrow bit saturates", sat_bit, 63);
    chk("R9 narrow err saturates", sat_err, 15);
    chk("R9 narrow still locked", sat_sync, 1);
  endtask

  task automatic t_disable();
    pat_sel = 0; prbs_len = 6'd7; prbs_tap = 6'd6; g_seed = 32'h19; g_k = 0;
    acquire_prbs("R10");
    enable = 1'b0;
    send_pat(1, 1'b0);
    chk("R10 disable drops lock", in_sync, 0);
    send_pat(19, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    chk("R10 nothing counted while off", bit_snap, 0);
    enable = 1'b1;
    send_pat(7 + 31, 1'b0);
    chk("R10 fresh search not yet", in_sync, 0);
    send_pat(1, 1'b0);
    chk("R10 fresh search lock", in_sync, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_prbs_acquire();
    t_prbs_restart();
    t_word();
    t_loss();
    t_sparse();
    t_snap();
    t_saturate();
    t_disable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule